// File: doc/BRIEF.md
# Page Write Collector and Commit Controller

This block sits between a serial-bus target front end and a byte-wide memory array. A write transaction begins with an address load, which picks one 128-byte page with the upper address bits and a starting byte position with the low seven bits. Each data byte that follows is placed in a page-sized holding buffer at the current position. The position then advances and wraps inside the page. When the transaction ends with a STOP, the bytes that were actually received are copied into the array. A busy period of fixed length then follows, so the array has time to program.

The write-protect input is looked at once per transaction, when the first data byte arrives. If it is high then, that byte and every later byte of the transaction are refused, and nothing is committed. If the transaction ends with no data byte stored, for example an address-only write before a repeated START, no commit and no busy period take place. While busy, the block refuses every data byte and ignores address loads. The front end uses the busy output to withhold its address acknowledge.

Top module: `page_commit_ctrl`

## Requirements
- R1: During and right after reset, `busy`, `mem_we`, `ack_vld` and `ack_ok` are all 0.
- R2: Every array write of a commit carries, in `mem_addr[15:7]`, the page given by `addr_in[15:7]` at the last address load.
- R3: The first data byte goes to byte position `addr_in[6:0]`, and each later byte goes to the next position modulo 128. With more than 128 bytes, the later bytes replace the earlier ones at the same position.
- R4: A commit writes only the positions loaded in this transaction. It writes each of them exactly once, with the last byte loaded there, in ascending address order, and only while `busy` is 1.
- R5: A STOP that ends a transaction with no stored data byte starts no commit, so `busy` stays 0.
- R6: If `wp_in` is 1 when the first data byte of a transaction arrives, that byte and all later bytes of the transaction get `ack_ok`=0. That STOP then starts no commit.
- R7: If `wp_in` is 0 at the first data byte, later values of `wp_in` have no effect, and all bytes of the transaction are accepted.
- R8: While `busy` is 1, every data byte gets `ack_ok`=0 and address loads are ignored.
- R9: Each `byte_stb` cycle is answered by `ack_vld`=1 in the next cycle and only then. `ack_ok` is 1 only together with `ack_vld`.
- R10: `busy` rises in the cycle after an accepting STOP. It stays high for 128 scan cycles, then for `CYCLE_TICKS` cycles with `tick`=1, and with `tick` held 0 it does not fall.
- R11: A data byte that is not preceded by an address load in the same transaction gets `ack_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Strobe: start a write transaction at `addr_in` |
| addr_in | input | 16 | Page (bits 15:7) and starting byte position (bits 6:0) |
| byte_stb | input | 1 | Strobe: one data byte on `byte_in` |
| byte_in | input | 8 | Data byte |
| txn_stop | input | 1 | Strobe: STOP ended the transaction |
| tick | input | 1 | Timebase pulse counted during the busy period |
| wp_in | input | 1 | Write protect, active high |
| ack_vld | output | 1 | Response to the previous cycle's data byte |
| ack_ok | output | 1 | That byte was accepted |
| busy | output | 1 | Commit or busy period in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 16 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
A wrong position pointer or a wrong mask bit shows up within one commit. The result is a write to an unexpected byte, a missing or repeated write, or a write with stale data. The bench matches each of these against a model of the page it builds from the stimulus. A write-protect latch that is sampled at the wrong point, or never cleared, changes `ack_ok` on the first refused or accepted byte of a transaction. A miscounting timer changes when `busy` falls, and the bench checks that cycle exactly.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_SCAN    = 2'd1,
        ST_HOLD    = 2'd2
    } pgw_state_e;
endpackage

// File: rtl/pgw_store.sv
// Page holding buffer with a per-byte loaded mask.
module pgw_store #(
    parameter int IDX_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_all,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    localparam int NBYTES = 1 << IDX_W;

    typedef struct packed {
        logic [NBYTES-1:0][DATA_W-1:0] data;
        logic [NBYTES-1:0]             valid;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_all) begin
            st_d.valid = '0;
        end
        if (wr_en) begin
            st_d.data[wr_idx]  = wr_data;
            st_d.valid[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.data[rd_idx];
    assign rd_valid  = st_q.valid[rd_idx];
    assign any_valid = |st_q.valid;
endmodule

// File: rtl/pgw_timer.sv
// Counts timebase ticks for the busy period after the scan.
module pgw_timer #(
    parameter int TICKS = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(TICKS + 1);

    typedef struct packed {
        logic          running;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    assign done = t_q.running && tick && (t_q.cnt == CW'(TICKS - 1));

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.running = 1'b1;
            t_d.cnt     = '0;
        end else if (t_q.running && tick) begin
            if (done) begin
                t_d.running = 1'b0;
                t_d.cnt     = '0;
            end else begin
                t_d.cnt = t_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl #(
    parameter int ADDR_W      = 16,
    parameter int IDX_W       = 7,
    parameter int DATA_W      = 8,
    parameter int CYCLE_TICKS = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              txn_stop,
    input  logic              tick,
    input  logic              wp_in,
    output logic              ack_vld,
    output logic              ack_ok,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    import pgw_pkg::*;

    localparam int               PG_W     = ADDR_W - IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'((1 << IDX_W) - 1);

    typedef struct packed {
        pgw_state_e        state;
        logic [PG_W-1:0]   page;
        logic [IDX_W-1:0]  ptr;
        logic [IDX_W-1:0]  scan;
        logic              armed;
        logic              wp_seen;
        logic              rejected;
        logic              ack_vld;
        logic              ack_ok;
        logic              mem_we;
        logic [ADDR_W-1:0] mem_addr;
        logic [DATA_W-1:0] mem_wdata;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic              st_wr, st_clr, st_rd_valid, st_any;
    logic [DATA_W-1:0] st_rd_data;
    logic              tmr_start, tmr_done;

    pgw_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (st_wr),
        .wr_idx    (c_q.ptr),
        .wr_data   (byte_in),
        .clr_all   (st_clr),
        .rd_idx    (c_q.scan),
        .rd_data   (st_rd_data),
        .rd_valid  (st_rd_valid),
        .any_valid (st_any)
    );

    pgw_timer #(.TICKS(CYCLE_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .tick  (tick),
        .done  (tmr_done)
    );

    always_comb begin
        c_d         = c_q;
        c_d.ack_vld = byte_stb;
        c_d.ack_ok  = 1'b0;
        c_d.mem_we  = 1'b0;
        st_wr       = 1'b0;
        st_clr      = 1'b0;
        tmr_start   = 1'b0;
        case (c_q.state)
            ST_COLLECT: begin
                if (addr_load) begin
                    c_d.page     = addr_in[ADDR_W-1:IDX_W];
                    c_d.ptr      = addr_in[IDX_W-1:0];
                    c_d.armed    = 1'b1;
                    c_d.wp_seen  = 1'b0;
                    c_d.rejected = 1'b0;
                    st_clr       = 1'b1;
                end else if (byte_stb) begin
                    if (c_q.armed && !c_q.rejected) begin
                        c_d.wp_seen = 1'b1;
                        if (!c_q.wp_seen && wp_in) begin
                            c_d.rejected = 1'b1;
                        end else begin
                            st_wr      = 1'b1;
                            c_d.ack_ok = 1'b1;
                            c_d.ptr    = c_q.ptr + IDX_W'(1);
                        end
                    end
                end else if (txn_stop) begin
                    c_d.armed = 1'b0;
                    if (st_any && !c_q.rejected) begin
                        c_d.state = ST_SCAN;
                        c_d.scan  = '0;
                    end else begin
                        st_clr = 1'b1;
                    end
                end
            end
            ST_SCAN: begin
                if (st_rd_valid) begin
                    c_d.mem_we    = 1'b1;
                    c_d.mem_addr  = {c_q.page, c_q.scan};
                    c_d.mem_wdata = st_rd_data;
                end
                if (c_q.scan == LAST_IDX) begin
                    c_d.state = ST_HOLD;
                    tmr_start = 1'b1;
                    st_clr    = 1'b1;
                end else begin
                    c_d.scan = c_q.scan + IDX_W'(1);
                end
            end
            ST_HOLD: begin
                if (tmr_done) c_d.state = ST_COLLECT;
            end
            default: c_d.state = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_COLLECT;
        end else begin
            c_q <= c_d;
        end
    end

    assign ack_vld   = c_q.ack_vld;
    assign ack_ok    = c_q.ack_ok;
    assign busy      = (c_q.state != ST_COLLECT);
    assign mem_we    = c_q.mem_we;
    assign mem_addr  = c_q.mem_addr;
    assign mem_wdata = c_q.mem_wdata;
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_stb,
    input logic              txn_stop,
    input logic              ack_vld,
    input logic              ack_ok,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    p_ack_after_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |=> ack_vld);

    p_ack_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |-> $past(byte_stb));

    p_ok_with_vld_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ok |-> ack_vld);

    p_busy_refuses_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && byte_stb) |=> !ack_ok);

    p_write_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    p_write_ascending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr > $past(mem_addr)));

    p_busy_from_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(txn_stop));
endmodule

bind page_commit_ctrl pgw_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pgw_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_stb (byte_stb),
    .txn_stop (txn_stop),
    .ack_vld  (ack_vld),
    .ack_ok   (ack_ok),
    .busy     (busy),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/test_page_commit_ctrl.sv
module test_page_commit_ctrl;
    localparam int TICKS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_load = 1'b0;
    logic [15:0] addr_in = '0;
    logic        byte_stb = 1'b0;
    logic [7:0]  byte_in = '0;
    logic        txn_stop = 1'b0;
    logic        tick = 1'b1;
    logic        wp_in = 1'b0;
    logic        ack_vld, ack_ok, busy, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;

    int checks = 0;
    int fails  = 0;
    int wr_seen = 0;
    bit         done_flag = 1'b0;
    bit [127:0] exp_valid;
    logic [7:0] exp_data [128];
    int         exp_page;

    always #5 clk = ~clk;

    page_commit_ctrl #(.CYCLE_TICKS(TICKS)) i_page_commit_ctrl (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_stb(byte_stb), .byte_in(byte_in), .txn_stop(txn_stop), .tick(tick),
        .wp_in(wp_in), .ack_vld(ack_vld), .ack_ok(ack_ok), .busy(busy),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Array write monitor against the page model
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            int idx;
            idx = int'(mem_addr[6:0]);
            wr_seen++;
            chk(int'(mem_addr[15:7]) == exp_page, "R2 page", int'(mem_addr[15:7]), exp_page);
            chk(exp_valid[idx] == 1'b1, "R4 loaded position", idx, 1);
            chk(mem_wdata == exp_data[idx], "R3 data", int'(mem_wdata), int'(exp_data[idx]));
            exp_valid[idx] = 1'b0;
        end
    end

    task automatic load_addr(input int a);
        @(negedge clk); addr_load = 1'b1; addr_in = 16'(a);
        @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ok);
        @(negedge clk); byte_stb = 1'b1; byte_in = d;
        @(negedge clk); ok = ack_ok;
        chk(ack_vld == 1'b1, "R9 ack_vld", int'(ack_vld), 1);
        byte_stb = 1'b0;
    endtask

    task automatic send_stop();
        @(negedge clk); txn_stop = 1'b1;
        @(negedge clk); txn_stop = 1'b0;
    endtask

    task automatic wait_idle(output int cnt);
        cnt = 0;
        while (busy && cnt < 5000) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic do_write(input int start, input int n, input bit wp_first, input bit wp_later);
        bit ok;
        int bcnt, uniq;
        exp_valid = '0;
        exp_page  = (start >> 7) & 511;
        wr_seen   = 0;
        load_addr(start);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = 8'((start * 3 + i * 29 + 5) & 255);
            wp_in = (i == 0) ? wp_first : wp_later;
            send_byte(d, ok);
            if (wp_first)
                chk(ok == 1'b0, "R6 refused", int'(ok), 0);
            else
                chk(ok == 1'b1, (i >= 128) ? "R3 wrap accept" : "R7 accept", int'(ok), 1);
            if (!wp_first) begin
                exp_valid[(start + i) & 127] = 1'b1;
                exp_data[(start + i) & 127]  = d;
            end
        end
        wp_in = 1'b0;
        @(negedge clk);
        chk(ack_vld == 1'b0, "R9 single ack", int'(ack_vld), 0);
        send_stop();
        if (wp_first) begin
            chk(busy == 1'b0, "R6 no commit", int'(busy), 0);
            repeat (5) @(negedge clk);
            chk(wr_seen == 0, "R6 no writes", wr_seen, 0);
        end else begin
            uniq = (n > 128) ? 128 : n;
            wait_idle(bcnt);
            chk(bcnt == 128 + TICKS, "R10 busy length", bcnt, 128 + TICKS);
            chk(wr_seen == uniq, "R4 write count", wr_seen, uniq);
            chk(exp_valid == '0, "R4 all committed", $countones(exp_valid), 0);
        end
    endtask

    initial begin
        bit ok;
        int cnt;
        int starts [4] = '{0, 16'h1234, 16'hFFFF, 16'h7F05};
        int lens   [4] = '{1, 37, 128, 130};
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && mem_we == 1'b0, "R1 reset outputs", int'(busy) + int'(mem_we), 0);
        chk(ack_vld == 1'b0 && ack_ok == 1'b0, "R1 reset ack", int'(ack_vld) + int'(ack_ok), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 after reset", int'(busy), 0);

        // R11: byte with no address load
        send_byte(8'hA5, ok);
        chk(ok == 1'b0, "R11 unaddressed byte", int'(ok), 0);

        // Sweep of start positions and lengths
        for (int s = 0; s < 4; s++)
            for (int l = 0; l < 4; l++)
                do_write(starts[s], lens[l], 1'b0, 1'b0);

        // R7: protect rising after the first byte has no effect
        do_write(16'h0240, 10, 1'b0, 1'b1);
        // R6: protect high at first byte
        do_write(16'h0300, 6, 1'b1, 1'b0);
        do_write(16'h0300, 3, 1'b1, 1'b1);

        // R5: address-only transaction
        load_addr(16'h4000);
        send_stop();
        chk(busy == 1'b0, "R5 no cycle", int'(busy), 0);
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R5 still idle", int'(busy), 0);

        // R8: refusal while busy, address load ignored
        exp_valid = '0; exp_page = 3; wr_seen = 0;
        load_addr(16'h0180);
        for (int i = 0; i < 4; i++) begin
            send_byte(8'(i + 1), ok);
            exp_valid[i] = 1'b1; exp_data[i] = 8'(i + 1);
        end
        send_stop();
        send_byte(8'h77, ok);
        chk(ok == 1'b0, "R8 byte while busy", int'(ok), 0);
        load_addr(16'h2200);
        wait_idle(cnt);
        chk(busy == 1'b0, "R8 idle again", int'(busy), 0);
        send_byte(8'h66, ok);
        chk(ok == 1'b0, "R8 load ignored R11", int'(ok), 0);
        send_stop();
        chk(busy == 1'b0, "R8 no commit", int'(busy), 0);

        // R10: no tick, busy holds
        exp_valid = '0; exp_page = 5; wr_seen = 0;
        load_addr(16'h0282);
        send_byte(8'h3C, ok);
        exp_valid[2] = 1'b1; exp_data[2] = 8'h3C;
        tick = 1'b0;
        send_stop();
        repeat (300) @(negedge clk);
        chk(busy == 1'b1, "R10 holds without tick", int'(busy), 1);
        chk(wr_seen == 1, "R4 single write", wr_seen, 1);
        tick = 1'b1;
        repeat (TICKS - 1) @(negedge clk);
        chk(busy == 1'b1, "R10 before last tick", int'(busy), 1);
        @(negedge clk);
        chk(busy == 1'b0, "R10 after last tick", int'(busy), 0);

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule